// File: doc/BRIEF.md
# Transceiver Management Registers with Digital Reset Sequencing

This block is the management slave of a multi-channel serial transceiver PHY. It sits on a word-addressed memory-mapped bus with 32-bit data, separate read and write strobes and a wait signal. Through it, software can do three things. It can read the lock state of the transmit PLLs. It can choose which channels take part in digital resets. It can start a transmit or a receive digital reset and then poll for completion.

Each direction, transmit and receive, has its own reset sequencer. A sequence holds the digital reset for a fixed number of management clocks. It then waits until every PLL reports lock, releases the reset and raises a ready flag. The sequencer's reset is gated per channel by the channel mask before it leaves the block. Both sequencers also start on a rising edge of the global PHY reset request. A synchronous block reset leaves both sequencers at the start of a sequence. The PLL lock bits are taken as already synchronous to the management clock.

Top module: `xcvr_mgmt_regs`

## Requirements
- R1: After the synchronous reset `rst`, the channel mask is all ones, both ready flags are 0, and both sequencers are holding reset. As a result, `tx_digital_rst` and `rx_digital_rst` are all ones and `bus_waitreq` is 0.
- R2: Every read holds `bus_waitreq` high for exactly one cycle. The read data is valid on `bus_rdata` in the following cycle, when `bus_waitreq` is low. Writes never raise `bus_waitreq`.
- R3: Reading word address 0x022 returns `pll_locked` in bits [NUM_PLL-1:0]. Bit p is PLL p, and all higher bits read as zero.
- R4: Word address 0x041 holds the channel mask, with bit n for channel n. A write stores bits [NUM_CH-1:0]. A read returns the stored mask with zeros above it.
- R5: A write to word address 0x042 with bit 0 set starts a transmit sequence, and with bit 1 set starts a receive sequence. These bits are not stored, and writing 0 to them does nothing.
- R6: Reading word address 0x042 returns the transmit ready flag in bit 0 and the receive ready flag in bit 1. When all PLLs are locked, the digital reset stays asserted for exactly RST_CYCLES cycles after a start, and the ready flag rises in the cycle it drops.
- R7: If any PLL is unlocked when the hold count runs out, the reset stays asserted. It drops, and ready rises, one cycle after the clock edge at which all lock bits are seen high.
- R8: `tx_digital_rst[n]` is the transmit sequencer's reset ANDed with mask bit n, and `rx_digital_rst[n]` is the same for the receive sequencer. A new mask takes effect in the cycle after its write.
- R9: A start that arrives while a sequence in the same direction is running restarts the hold count from zero. Any start clears that direction's ready flag in the next cycle.
- R10: A rising edge on `phy_rst_req` starts both sequencers. Holding the input high does not start them again.
- R11: Reads of any other word address return zero. Writes to any other word address change neither the mask nor the sequencers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Management clock |
| rst | input | 1 | Synchronous active-high block reset |
| phy_rst_req | input | 1 | Global PHY reset request; a rising edge starts both sequencers |
| pll_locked | input | NUM_PLL | Lock indication per transmit PLL |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | DATA_W | Write data |
| bus_write | input | 1 | Write strobe |
| bus_read | input | 1 | Read strobe |
| bus_rdata | output | DATA_W | Read data |
| bus_waitreq | output | 1 | Wait request; high in the first cycle of a read |
| tx_digital_rst | output | NUM_CH | Per-channel transmit digital reset |
| rx_digital_rst | output | NUM_CH | Per-channel receive digital reset |

## Verification
A write or a global-request edge is sampled at the next clock edge. The channel resets and the ready flags change in the cycle after that edge, and a read's data appears in the cycle after its single wait cycle. The bench carries a behavioural model that it advances at each rising edge from the inputs it drove. Just before each edge it compares the channel resets and the wait signal, and it compares `bus_rdata` only in the cycle where a read completes. Directed checks count the exact number of cycles a reset is held after a start, a restart or a late lock.

// File: rtl/xcvr_mgmt_pkg.sv
package xcvr_mgmt_pkg;

  localparam int unsigned MAP_ADDR_W   = 9;
  localparam logic [MAP_ADDR_W-1:0] A_PLL_LOCK = 9'h022;
  localparam logic [MAP_ADDR_W-1:0] A_CH_MASK  = 9'h041;
  localparam logic [MAP_ADDR_W-1:0] A_RST_CTRL = 9'h042;

  // Direction indices into the sequencer array; bit d of the control word starts direction d
  localparam int unsigned DIR_TX  = 0;
  localparam int unsigned DIR_RX  = 1;
  localparam int unsigned NUM_DIR = 2;

  typedef enum logic [1:0] {
    SEQ_HOLD     = 2'd0,
    SEQ_LOCKWAIT = 2'd1,
    SEQ_READY    = 2'd2
  } seq_state_t;

endpackage

// File: rtl/xcvr_rst_seq.sv
module xcvr_rst_seq
  import xcvr_mgmt_pkg::*;
#(
  parameter int unsigned RST_CYCLES = 16,
  parameter int unsigned NUM_PLL    = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [NUM_PLL-1:0] pll_locked,
  output logic               rst_active,
  output logic               ready
);

  localparam int unsigned CNT_W = (RST_CYCLES < 2) ? 1 : $clog2(RST_CYCLES);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RST_CYCLES - 1);

  seq_state_t       state;
  logic [CNT_W-1:0] cnt;
  logic             all_locked;

  assign all_locked = &pll_locked;

  always_ff @(posedge clk) begin
    if (rst || start) begin
      state <= SEQ_HOLD;
      cnt   <= '0;
    end else begin
      case (state)
        SEQ_HOLD: begin
          if (cnt == CNT_LAST) begin
            state <= all_locked ? SEQ_READY : SEQ_LOCKWAIT;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        SEQ_LOCKWAIT: begin
          if (all_locked) state <= SEQ_READY;
        end
        SEQ_READY: state <= SEQ_READY;
        default:   state <= SEQ_HOLD;
      endcase
    end
  end

  assign rst_active = (state != SEQ_READY);
  assign ready      = (state == SEQ_READY);

  // Length of the current reset window, used only to check the minimum hold time
  logic [31:0] hold_len;
  always_ff @(posedge clk) begin
    if (rst)             hold_len <= '0;
    else if (rst_active) hold_len <= hold_len + 1'b1;
    else                 hold_len <= '0;
  end

  a_r6_min_hold: assert property (@(posedge clk) disable iff (rst)
    $fell(rst_active) |-> (hold_len >= RST_CYCLES));

  a_r7_ready_needs_lock: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) |-> $past(all_locked));

  a_r9_start_restarts: assert property (@(posedge clk) disable iff (rst)
    start |=> (rst_active && !ready));

endmodule

// File: rtl/xcvr_mgmt_csr.sv
module xcvr_mgmt_csr
  import xcvr_mgmt_pkg::*;
#(
  parameter int unsigned ADDR_W  = 9,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned NUM_CH  = 4,
  parameter int unsigned NUM_PLL = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  input  logic               write,
  input  logic               read,
  input  logic [NUM_PLL-1:0] pll_locked,
  input  logic [NUM_DIR-1:0] seq_ready,
  output logic [DATA_W-1:0]  rdata,
  output logic               waitreq,
  output logic [NUM_CH-1:0]  ch_mask,
  output logic [NUM_DIR-1:0] wr_start
);

  localparam logic [ADDR_W-1:0] AD_LOCK = ADDR_W'(A_PLL_LOCK);
  localparam logic [ADDR_W-1:0] AD_MASK = ADDR_W'(A_CH_MASK);
  localparam logic [ADDR_W-1:0] AD_CTRL = ADDR_W'(A_RST_CTRL);

  logic              rd_phase;
  logic              rd_accept;
  logic [DATA_W-1:0] rd_mux;
  logic              hit_mask;
  logic              hit_ctrl;

  assign hit_mask  = (addr == AD_MASK);
  assign hit_ctrl  = (addr == AD_CTRL);
  assign rd_accept = read && !rd_phase;
  assign waitreq   = rd_accept;

  always_comb begin
    case (addr)
      AD_LOCK: rd_mux = DATA_W'(pll_locked);
      AD_MASK: rd_mux = DATA_W'(ch_mask);
      AD_CTRL: rd_mux = DATA_W'(seq_ready);
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_phase <= 1'b0;
      rdata    <= '0;
      ch_mask  <= '1;
    end else begin
      rd_phase <= rd_accept;
      if (rd_accept)          rdata   <= rd_mux;
      if (write && hit_mask)  ch_mask <= wdata[NUM_CH-1:0];
    end
  end

  // Command bits are pulses for the sequencers, never stored
  assign wr_start = (write && hit_ctrl) ? wdata[NUM_DIR-1:0] : '0;

  a_r2_one_wait: assert property (@(posedge clk) disable iff (rst)
    (read && waitreq) |=> !waitreq);

  a_r4_mask_write: assert property (@(posedge clk) disable iff (rst)
    (write && hit_mask) |=> (ch_mask == $past(wdata[NUM_CH-1:0])));

  a_r11_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    (read && waitreq && (addr != AD_LOCK) && !hit_mask && !hit_ctrl) |=> (rdata == '0));

endmodule

// File: rtl/xcvr_mgmt_regs.sv
module xcvr_mgmt_regs
  import xcvr_mgmt_pkg::*;
#(
  parameter int unsigned ADDR_W     = 9,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned NUM_CH     = 4,
  parameter int unsigned NUM_PLL    = 2,
  parameter int unsigned RST_CYCLES = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               phy_rst_req,
  input  logic [NUM_PLL-1:0] pll_locked,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  input  logic               bus_write,
  input  logic               bus_read,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic               bus_waitreq,
  output logic [NUM_CH-1:0]  tx_digital_rst,
  output logic [NUM_CH-1:0]  rx_digital_rst
);

  logic [NUM_CH-1:0]  ch_mask;
  logic [NUM_DIR-1:0] wr_start;
  logic [NUM_DIR-1:0] seq_active;
  logic [NUM_DIR-1:0] seq_ready;
  logic               req_q;
  logic               glob_start;

  always_ff @(posedge clk) begin
    if (rst) req_q <= 1'b0;
    else     req_q <= phy_rst_req;
  end
  assign glob_start = phy_rst_req && !req_q;

  xcvr_mgmt_csr #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .NUM_CH (NUM_CH),
    .NUM_PLL(NUM_PLL)
  ) u_csr (
    .clk       (clk),
    .rst       (rst),
    .addr      (bus_addr),
    .wdata     (bus_wdata),
    .write     (bus_write),
    .read      (bus_read),
    .pll_locked(pll_locked),
    .seq_ready (seq_ready),
    .rdata     (bus_rdata),
    .waitreq   (bus_waitreq),
    .ch_mask   (ch_mask),
    .wr_start  (wr_start)
  );

  for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
    xcvr_rst_seq #(
      .RST_CYCLES(RST_CYCLES),
      .NUM_PLL   (NUM_PLL)
    ) u_seq (
      .clk       (clk),
      .rst       (rst),
      .start     (wr_start[d] || glob_start),
      .pll_locked(pll_locked),
      .rst_active(seq_active[d]),
      .ready     (seq_ready[d])
    );
  end

  assign tx_digital_rst = {NUM_CH{seq_active[DIR_TX]}} & ch_mask;
  assign rx_digital_rst = {NUM_CH{seq_active[DIR_RX]}} & ch_mask;

  a_r10_level_no_restart: assert property (@(posedge clk) disable iff (rst)
    (phy_rst_req && $past(phy_rst_req) && !bus_write && seq_ready[DIR_TX]) |=> seq_ready[DIR_TX]);

endmodule

// File: tb/xcvr_mgmt_regs_bench.sv
module xcvr_mgmt_regs_bench;

  localparam int RST_CYC = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        phy_rst_req = 1'b0;
  logic [1:0]  pll_locked = 2'b11;
  logic [8:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_write = 1'b0;
  logic        bus_read = 1'b0;
  logic [31:0] bus_rdata;
  logic        bus_waitreq;
  logic [3:0]  tx_digital_rst;
  logic [3:0]  rx_digital_rst;

  always #10 clk = ~clk;

  xcvr_mgmt_regs #(
    .ADDR_W(9), .DATA_W(32), .NUM_CH(4), .NUM_PLL(2), .RST_CYCLES(RST_CYC)
  ) u_xcvr_mgmt_regs (
    .clk(clk), .rst(rst), .phy_rst_req(phy_rst_req), .pll_locked(pll_locked),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_write(bus_write),
    .bus_read(bus_read), .bus_rdata(bus_rdata), .bus_waitreq(bus_waitreq),
    .tx_digital_rst(tx_digital_rst), .rx_digital_rst(rx_digital_rst)
  );

  int    checks = 0;
  int    failures = 0;
  bit    cmp_en = 1'b0;
  string tag = "R1";

  // Behavioural reference: phase 0 = holding, 1 = waiting for lock, 2 = ready
  int          m_ph [2];
  int          m_cnt [2];
  logic [3:0]  m_mask;
  bit          m_rdph;
  bit          m_prev;
  logic [31:0] m_rdata;

  always @(posedge clk) begin
    bit st [2];
    bit lk;
    lk = &pll_locked;
    if (rst) begin
      for (int d = 0; d < 2; d++) begin m_ph[d] = 0; m_cnt[d] = 0; end
      m_mask = 4'hF; m_rdph = 0; m_prev = 0; m_rdata = 0;
    end else begin
      for (int d = 0; d < 2; d++)
        st[d] = (phy_rst_req && !m_prev) || (bus_write && bus_addr == 9'h042 && bus_wdata[d]);
      if (bus_read && !m_rdph) begin
        case (bus_addr)
          9'h022:  m_rdata = {30'b0, pll_locked};
          9'h041:  m_rdata = {28'b0, m_mask};
          9'h042:  m_rdata = {30'b0, m_ph[1] == 2, m_ph[0] == 2};
          default: m_rdata = 32'h0;
        endcase
      end
      m_rdph = bus_read && !m_rdph;
      if (bus_write && bus_addr == 9'h041) m_mask = bus_wdata[3:0];
      for (int d = 0; d < 2; d++) begin
        if (st[d]) begin
          m_ph[d] = 0; m_cnt[d] = 0;
        end else if (m_ph[d] == 0) begin
          if (m_cnt[d] == RST_CYC - 1) m_ph[d] = lk ? 2 : 1;
          else m_cnt[d] = m_cnt[d] + 1;
        end else if (m_ph[d] == 1 && lk) begin
          m_ph[d] = 2;
        end
      end
      m_prev = phy_rst_req;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string rd_tag(input logic [8:0] a);
    case (a)
      9'h022:  return "R3";
      9'h041:  return "R4";
      9'h042:  return "R6";
      default: return "R11";
    endcase
  endfunction

  // Compare just before the edge, then advance one cycle
  task automatic tick();
    #1;
    if (cmp_en) begin
      chk({tag, " tx_digital_rst"}, {28'b0, tx_digital_rst}, {28'b0, (m_ph[0] != 2) ? m_mask : 4'h0});
      chk({tag, " rx_digital_rst"}, {28'b0, rx_digital_rst}, {28'b0, (m_ph[1] != 2) ? m_mask : 4'h0});
      chk("R2 waitreq", {31'b0, bus_waitreq}, {31'b0, bus_read && !m_rdph});
      if (bus_read && m_rdph) chk(rd_tag(bus_addr), bus_rdata, m_rdata);
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic do_write(input logic [8:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_write = 1'b1;
    tick();
    bus_write = 1'b0;
  endtask

  task automatic do_read(input logic [8:0] a, output logic [31:0] d);
    bus_addr = a; bus_read = 1'b1;
    tick();
    #1 d = bus_rdata;
    tick();
    bus_read = 1'b0;
  endtask

  // Cycles the transmit reset stays asserted, starting now
  task automatic count_tx(output int n);
    n = 0;
    while (tx_digital_rst != 4'h0 && n < 200) begin n++; tick(); end
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=<20000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    int n;
    @(negedge clk);
    ticks(3);
    rst = 1'b0;
    #1;
    chk("R1 tx after reset", {28'b0, tx_digital_rst}, 32'hF);
    chk("R1 rx after reset", {28'b0, rx_digital_rst}, 32'hF);
    chk("R1 waitreq after reset", {31'b0, bus_waitreq}, 32'h0);
    cmp_en = 1'b1;
    do_read(9'h041, rd); chk("R1 mask", rd, 32'hF);
    do_read(9'h042, rd); chk("R1 ready low", rd, 32'h0);
    ticks(20);

    tag = "R6";
    do_read(9'h042, rd); chk("R6 both ready", rd, 32'h3);
    do_write(9'h042, 32'h1);
    count_tx(n); chk("R6 hold length", n, RST_CYC);
    do_read(9'h042, rd); chk("R6 tx ready only restarted dir", rd, 32'h3);

    tag = "R3";
    pll_locked = 2'b10; tick();
    do_read(9'h022, rd); chk("R3 lock 10", rd, 32'h2);
    pll_locked = 2'b01; tick();
    do_read(9'h022, rd); chk("R3 lock 01", rd, 32'h1);
    pll_locked = 2'b11; tick();

    tag = "R4";
    do_write(9'h041, 32'hFFFF_FFF5);
    do_read(9'h041, rd); chk("R4 mask stored", rd, 32'h5);

    tag = "R8";
    do_write(9'h042, 32'h2);
    chk("R8 rx gated", {28'b0, rx_digital_rst}, 32'h5);
    ticks(4);
    do_write(9'h041, 32'hA);
    chk("R8 mask change next cycle", {28'b0, rx_digital_rst}, 32'hA);
    ticks(20);
    do_write(9'h041, 32'hF);

    tag = "R7";
    pll_locked = 2'b01;
    do_write(9'h042, 32'h1);
    ticks(30);
    chk("R7 held while unlocked", {28'b0, tx_digital_rst}, 32'hF);
    pll_locked = 2'b11;
    tick();
    chk("R7 release after lock", {28'b0, tx_digital_rst}, 32'h0);

    tag = "R9";
    do_write(9'h042, 32'h1);
    do_read(9'h042, rd); chk("R9 ready cleared", rd, 32'h2);
    ticks(6);
    do_write(9'h042, 32'h1);
    count_tx(n); chk("R9 restart full hold", n, RST_CYC);

    tag = "R5";
    do_write(9'h042, 32'hFFFF_FFFC);
    chk("R5 no start tx", {28'b0, tx_digital_rst}, 32'h0);
    chk("R5 no start rx", {28'b0, rx_digital_rst}, 32'h0);
    do_read(9'h042, rd); chk("R5 ready unchanged", rd, 32'h3);

    tag = "R11";
    do_write(9'h000, 32'hFFFF_FFFF);
    do_write(9'h043, 32'h0);
    do_write(9'h1FF, 32'h3);
    chk("R11 no start", {28'b0, tx_digital_rst | rx_digital_rst}, 32'h0);
    do_read(9'h041, rd); chk("R11 mask untouched", rd, 32'hF);
    do_read(9'h1FF, rd); chk("R11 unmapped read", rd, 32'h0);
    do_read(9'h023, rd); chk("R11 unmapped read 023", rd, 32'h0);

    tag = "R10";
    phy_rst_req = 1'b1;
    tick();
    chk("R10 tx started", {28'b0, tx_digital_rst}, 32'hF);
    chk("R10 rx started", {28'b0, rx_digital_rst}, 32'hF);
    ticks(40);
    do_read(9'h042, rd); chk("R10 level does not retrigger", rd, 32'h3);
    phy_rst_req = 1'b0;
    ticks(3);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule